// File: doc/BRIEF.md
# Boundary-Scan Pin Cell Chain

This block sits between the core and the I/O buffers of a set of pins and gives an external test controller serial access to every pin. Each pin owns three scan cells: one observing the enable the core gives the buffer, one observing the core's data toward the pad, and one observing the value arriving from the pad. All cells are strung into a single serial path from `scanIn` to `scanOut`. Every cell holds a shift flop and a separate update latch. The shift flops move and capture data. The update latches hold what the pins see in the test modes.

The controller drives three strobes (capture, shift, update) and a 3-bit mode code. In functional and sample modes the pins behave as though the block were absent, while a capture still takes a snapshot of the live signals. In external-test mode the pads are driven from the update latches, and the core sees the latched input value. Clamp mode also drives the pads from the latches but leaves the core's input path live. High-impedance mode turns every buffer enable off.

Top module: `bscan_pin_chain`

## Requirements
- R1: The chain holds 3*NUM_PINS cells. Starting from `scanIn`, the cells run pin 0 control, pin 0 output, pin 0 input, pin 1 control, and so on. The pin NUM_PINS-1 input cell is last, and its shift flop drives `scanOut` directly.
- R2: On a rising edge with `shiftEn` high and `captureEn` low, every shift flop takes the value of its neighbour on the `scanIn` side, and the first cell takes `scanIn`.
- R3: On a rising edge with `captureEn` high, capture takes priority over shift. For each pin p, the input cell loads `padIn[p]`, the output cell loads `coreOut[p]`, and the control cell loads `coreOe[p]`.
- R4: On a rising edge with `updateEn` high, every update latch copies its shift flop. At other times the latches hold, so shifting and capture never change what the pins see in the latch-driven modes.
- R5: Functional mode (code 0) and sample mode (code 2) are transparent: `padOut`=`coreOut`, `padOe`=`coreOe` and `coreIn`=`padIn`. The unused codes 5 to 7 behave the same way.
- R6: In external-test mode (code 1), `padOut[p]` is the pin's output latch, `padOe[p]` is its control latch, and `coreIn[p]` is its input latch.
- R7: In high-impedance mode (code 3), every bit of `padOe` is 0, whatever the latches hold. `padOut` follows `coreOut` and `coreIn` follows `padIn`.
- R8: In clamp mode (code 4), `padOut` and `padOe` come from the output and control latches, and `coreIn` follows `padIn`.
- R9: While `rstN` is low, all shift flops and update latches clear to 0, so `scanOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous active-low reset |
| testMode | input | 3 | Mode code: 0 functional, 1 external test, 2 sample, 3 high-Z, 4 clamp |
| captureEn | input | 1 | Capture strobe |
| shiftEn | input | 1 | Shift strobe |
| updateEn | input | 1 | Update strobe |
| scanIn | input | 1 | Serial data into the first cell |
| scanOut | output | 1 | Serial data from the last cell |
| coreOut | input | NUM_PINS | Core data toward the pads |
| coreOe | input | NUM_PINS | Core output enables |
| coreIn | output | NUM_PINS | Pad data as seen by the core |
| padOut | output | NUM_PINS | Data to the pad buffers |
| padOe | output | NUM_PINS | Enables to the pad buffers |
| padIn | input | NUM_PINS | Values sampled at the pads |

## Verification
The hardest condition to reach is external-test mode with new data in the shift flops that has not yet been committed. This is the case where a missing update latch would make the pads ripple. The stimulus commits one pattern, then shifts a complete different pattern through without an update strobe, checking the pads after every bit. Only after that does it pulse the update strobe and confirm that the new pattern appears. Capture priority is reached by raising the capture and shift strobes in the same cycle and then reading the whole chain back out.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [2:0] {
    MODE_FUNC   = 3'd0,
    MODE_EXTEST = 3'd1,
    MODE_SAMPLE = 3'd2,
    MODE_HIGHZ  = 3'd3,
    MODE_CLAMP  = 3'd4
  } scanMode_t;

  // Strobes and pin-mux selects from control to datapath
  typedef struct packed {
    logic doCapture;
    logic doShift;
    logic doUpdate;
    logic pinsFromScan;
    logic coreFromScan;
    logic forceHiZ;
  } scanCtl_t;

  localparam int CELLS_PER_PIN = 3;
  localparam int OFS_CTL = 0;
  localparam int OFS_OUT = 1;
  localparam int OFS_IN  = 2;

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic clk,
  input  logic rstN,
  input  logic capEn,
  input  logic shEn,
  input  logic updEn,
  input  logic serIn,
  input  logic parIn,
  output logic serOut,
  output logic parOut
);

  logic shiftQ;
  logic updQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      shiftQ <= 1'b0;
    else if (capEn) shiftQ <= parIn;
    else if (shEn)  shiftQ <= serIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      updQ <= 1'b0;
    else if (updEn) updQ <= shiftQ;
  end

  assign serOut = shiftQ;
  assign parOut = updQ;

  // R4: the latch moves only on an update strobe
  a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rstN)
    !updEn |=> (parOut == $past(parOut)));

endmodule

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic     [2:0] testMode,
  input  logic           captureEn,
  input  logic           shiftEn,
  input  logic           updateEn,
  output scanCtl_t       ctl
);

  always_comb begin
    ctl              = '0;
    ctl.doCapture    = captureEn;
    ctl.doShift      = shiftEn & ~captureEn;
    ctl.doUpdate     = updateEn;
    case (testMode)
      MODE_EXTEST: begin
        ctl.pinsFromScan = 1'b1;
        ctl.coreFromScan = 1'b1;
      end
      MODE_CLAMP: begin
        ctl.pinsFromScan = 1'b1;
      end
      MODE_HIGHZ: begin
        ctl.forceHiZ = 1'b1;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  scanCtl_t            ctl,
  input  logic                scanIn,
  output logic                scanOut,
  input  logic [NUM_PINS-1:0] coreOut,
  input  logic [NUM_PINS-1:0] coreOe,
  output logic [NUM_PINS-1:0] coreIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  input  logic [NUM_PINS-1:0] padIn
);

  localparam int NUM_CELLS = CELLS_PER_PIN * NUM_PINS;

  logic [NUM_CELLS-1:0] serLink;
  logic [NUM_CELLS-1:0] cellPar;
  logic [NUM_CELLS-1:0] cellUpd;

  // Parallel capture sources per pin
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_src
    assign cellPar[CELLS_PER_PIN*p + OFS_CTL] = coreOe[p];
    assign cellPar[CELLS_PER_PIN*p + OFS_OUT] = coreOut[p];
    assign cellPar[CELLS_PER_PIN*p + OFS_IN]  = padIn[p];
  end

  // Serial chain, cell 0 nearest scanIn
  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    logic serSrc;
    if (c == 0) begin : g_head
      assign serSrc = scanIn;
    end else begin : g_body
      assign serSrc = serLink[c-1];
    end
    bscan_cell u_cell (
      .clk   (clk),
      .rstN  (rstN),
      .capEn (ctl.doCapture),
      .shEn  (ctl.doShift),
      .updEn (ctl.doUpdate),
      .serIn (serSrc),
      .parIn (cellPar[c]),
      .serOut(serLink[c]),
      .parOut(cellUpd[c])
    );
  end

  assign scanOut = serLink[NUM_CELLS-1];

  // Pin multiplexers
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_mux
    always_comb begin
      padOut[p] = ctl.pinsFromScan ? cellUpd[CELLS_PER_PIN*p + OFS_OUT] : coreOut[p];
      if (ctl.forceHiZ)          padOe[p] = 1'b0;
      else if (ctl.pinsFromScan) padOe[p] = cellUpd[CELLS_PER_PIN*p + OFS_CTL];
      else                       padOe[p] = coreOe[p];
      coreIn[p] = ctl.coreFromScan ? cellUpd[CELLS_PER_PIN*p + OFS_IN] : padIn[p];
    end
  end

  // R3: a capture puts the last pin's pad value on the serial output
  a_r3_capture_pad: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doCapture |=> (scanOut == $past(padIn[NUM_PINS-1])));

  // R2: a shift moves the second-to-last cell onto the serial output
  if (NUM_CELLS > 1) begin : g_shift_chk
    a_r2_shift_step: assert property (@(posedge clk) disable iff (!rstN)
      ctl.doShift |=> (scanOut == $past(serLink[NUM_CELLS-2])));
  end

endmodule

// File: rtl/bscan_pin_chain.sv
module bscan_pin_chain
  import bscan_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          testMode,
  input  logic                captureEn,
  input  logic                shiftEn,
  input  logic                updateEn,
  input  logic                scanIn,
  output logic                scanOut,
  input  logic [NUM_PINS-1:0] coreOut,
  input  logic [NUM_PINS-1:0] coreOe,
  output logic [NUM_PINS-1:0] coreIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  input  logic [NUM_PINS-1:0] padIn
);

  scanCtl_t ctl;

  bscan_ctrl u_ctrl (
    .testMode (testMode),
    .captureEn(captureEn),
    .shiftEn  (shiftEn),
    .updateEn (updateEn),
    .ctl      (ctl)
  );

  bscan_chain #(.NUM_PINS(NUM_PINS)) u_chain (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .scanIn (scanIn),
    .scanOut(scanOut),
    .coreOut(coreOut),
    .coreOe (coreOe),
    .coreIn (coreIn),
    .padOut (padOut),
    .padOe  (padOe),
    .padIn  (padIn)
  );

  // R7: high-Z mode never enables a buffer
  a_r7_hiz_off: assert property (@(posedge clk) disable iff (!rstN)
    (testMode == 3'd3) |-> (padOe == '0));

  // R5: functional mode is transparent
  a_r5_func_pass: assert property (@(posedge clk) disable iff (!rstN)
    (testMode == 3'd0) |-> (padOut == coreOut && padOe == coreOe && coreIn == padIn));

  // R4: no pad ripple in external test without an update
  a_r4_no_ripple: assert property (@(posedge clk) disable iff (!rstN)
    (testMode == 3'd1 && !updateEn) |=>
      (testMode != 3'd1 || ($stable(padOut) && $stable(padOe))));

endmodule

// File: tb/tb_bscan_pin_chain.sv
module tb_bscan_pin_chain;

  localparam int NP = 4;
  localparam int NC = 3 * NP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] testMode = 3'd0;
  logic captureEn = 1'b0, shiftEn = 1'b0, updateEn = 1'b0, scanIn = 1'b0;
  logic scanOut;
  logic [NP-1:0] coreOut = '0, coreOe = '0, padIn = '0;
  logic [NP-1:0] coreIn, padOut, padOe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [NC-1:0] mShift = '0;
  logic [NC-1:0] mUpd = '0;

  always #5 clk = ~clk;

  bscan_pin_chain #(.NUM_PINS(NP)) dut (
    .clk(clk), .rstN(rstN), .testMode(testMode), .captureEn(captureEn),
    .shiftEn(shiftEn), .updateEn(updateEn), .scanIn(scanIn), .scanOut(scanOut),
    .coreOut(coreOut), .coreOe(coreOe), .coreIn(coreIn), .padOut(padOut),
    .padOe(padOe), .padIn(padIn)
  );

  // {mode, coreOut, coreOe, padIn}
  localparam int NV = 10;
  localparam logic [14:0] VEC [NV] = '{
    {3'd0, 4'hA, 4'h5, 4'h3},
    {3'd2, 4'h6, 4'hF, 4'h9},
    {3'd1, 4'hF, 4'hF, 4'hF},
    {3'd1, 4'h0, 4'h0, 4'h0},
    {3'd3, 4'hC, 4'hF, 4'h5},
    {3'd3, 4'h3, 4'hA, 4'hE},
    {3'd4, 4'h0, 4'hF, 4'h7},
    {3'd4, 4'hF, 4'h0, 4'h8},
    {3'd5, 4'h9, 4'h6, 4'h1},
    {3'd7, 4'h4, 4'hB, 4'hD}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic shiftBit(input logic b);
    shiftEn = 1'b1; scanIn = b;
    step();
    shiftEn = 1'b0;
    mShift = {mShift[NC-2:0], b};
    #1;
    check(scanOut == mShift[NC-1], "R2 shift", {31'd0, scanOut}, {31'd0, mShift[NC-1]});
  endtask

  task automatic doUpdate();
    updateEn = 1'b1;
    step();
    updateEn = 1'b0;
    mUpd = mShift;
  endtask

  task automatic doCapture(input logic alsoShift);
    captureEn = 1'b1; shiftEn = alsoShift;
    step();
    captureEn = 1'b0; shiftEn = 1'b0;
    for (int p = 0; p < NP; p++) begin
      mShift[3*p]   = coreOe[p];
      mShift[3*p+1] = coreOut[p];
      mShift[3*p+2] = padIn[p];
    end
  endtask

  task automatic checkPins();
    logic [NP-1:0] eOut, eOe, eCi;
    string req;
    for (int p = 0; p < NP; p++) begin
      case (testMode)
        3'd1: begin eOut[p] = mUpd[3*p+1]; eOe[p] = mUpd[3*p]; eCi[p] = mUpd[3*p+2]; end
        3'd3: begin eOut[p] = coreOut[p]; eOe[p] = 1'b0; eCi[p] = padIn[p]; end
        3'd4: begin eOut[p] = mUpd[3*p+1]; eOe[p] = mUpd[3*p]; eCi[p] = padIn[p]; end
        default: begin eOut[p] = coreOut[p]; eOe[p] = coreOe[p]; eCi[p] = padIn[p]; end
      endcase
    end
    case (testMode)
      3'd1: req = "R6 extest";
      3'd3: req = "R7 highz";
      3'd4: req = "R8 clamp";
      default: req = "R5 transparent";
    endcase
    #1;
    check({padOut, padOe, coreIn} == {eOut, eOe, eCi}, req,
          {20'd0, padOut, padOe, coreIn}, {20'd0, eOut, eOe, eCi});
  endtask

  initial begin : watchdog
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [NC-1:0] pat;
    logic [NC-1:0] pat2;
    logic [NP-1:0] holdOut, holdOe;
    // R9 reset state
    testMode = 3'd1;
    repeat (3) @(posedge clk);
    #3;
    check(scanOut == 1'b0, "R9 reset scanOut", {31'd0, scanOut}, 32'd0);
    check(padOut == '0 && padOe == '0 && coreIn == '0, "R9 reset latches",
          {20'd0, padOut, padOe, coreIn}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    step();

    // R1/R2: fill the chain and watch the serial output
    pat = 12'b1011_0110_0101;
    for (int i = 0; i < NC; i++) shiftBit(pat[i]);
    // R1: first bit shifted in now sits at the TDO end
    check(scanOut == pat[0], "R1 chain length", {31'd0, scanOut}, {31'd0, pat[0]});
    doUpdate();

    // vector table over modes
    for (int v = 0; v < NV; v++) begin
      {testMode, coreOut, coreOe, padIn} = VEC[v];
      checkPins();
    end

    // R4: new pattern shifted in extest, pads must hold until update
    testMode = 3'd1;
    #1;
    holdOut = padOut; holdOe = padOe;
    pat2 = ~pat;
    for (int i = 0; i < NC; i++) begin
      shiftBit(pat2[i]);
      check(padOut == holdOut && padOe == holdOe, "R4 no ripple",
            {24'd0, padOut, padOe}, {24'd0, holdOut, holdOe});
    end
    doUpdate();
    checkPins();
    check(padOut != holdOut, "R4 update applies", {28'd0, padOut}, {28'd0, ~holdOut});

    // R3: capture with shift also raised, in sample mode
    testMode = 3'd2;
    coreOut = 4'b1001; coreOe = 4'b0110; padIn = 4'b1100;
    doCapture(1'b1);
    #1;
    check(scanOut == padIn[NP-1], "R3 capture first bit", {31'd0, scanOut}, {31'd0, padIn[NP-1]});
    for (int i = 0; i < NC; i++) shiftBit(1'b0);
    check(scanOut == 1'b0, "R3 capture drained", {31'd0, scanOut}, 32'd0);

    // R3: second capture pattern, read via shifts
    coreOut = 4'b0110; coreOe = 4'b1011; padIn = 4'b0011;
    doCapture(1'b0);
    for (int i = 0; i < NC; i++) shiftBit(1'b1);

    // R8 clamp and R7 highz after reload
    doUpdate();
    testMode = 3'd4; coreOut = 4'h5; padIn = 4'hA;
    checkPins();
    testMode = 3'd3;
    checkPins();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule